// File: doc/BRIEF.md
# Receive Wake-up Power Sequencer

This block runs duty-cycled reception for a radio. While idle it holds everything powered down and waits for a falling edge on a chosen start pin. After that edge it enables the frequency synthesizer and waits for the PLL to report lock. It then waits a coded settling time, counted in ADC-clock ticks, and enables the receive chain. A listen window follows, counted in filter-clock ticks. If carrier sense appears inside the window, the block keeps the receiver on until the host forces power-down. Otherwise it returns to sleep. On its way back it may first request a PLL calibration, depending on a policy that counts sequences.

The whole block runs on one system clock. The two slower clock domains reach it as one-cycle tick strobes. A bounded lock wait guards against a PLL that never locks: when the wait expires, the block raises a sticky error flag and goes back to sleep.

Top module: `wakeSeqTop`

## Requirements
- R1: The sequencer is active only while `pdMode` is 2'b11 and `txMode` is 0. In any other configuration every output enable (`synthPwrEn`, `rxPwrEn`, `calStart`) is low one cycle later, and start edges are ignored.
- R2: With `startFromSel`=1, a falling edge on `selPin` starts a sequence. With `startFromSel`=0 and `sepDataIo`=1, a falling edge on `dataPin` starts it. Any other pin/setting combination starts nothing. A start edge is acted on only while asleep.
- R3: The clock edge that sees the start edge enables `synthPwrEn` with `rxPwrEn` low. The block stays in the lock wait until `pllLock` is sampled high.
- R4: After lock, `settleCode` selects 32, 44, 64, 88, 128, 176 or 256 `adcTick` strobes (codes 0 to 6) before `rxPwrEn` rises. Code 7 enables the receiver on the cycle after lock.
- R5: With the receiver on, `listenCode` 0..15 selects a window of 20, 22, 24, 26, 28, 30, 32, 36, 40, 44, 48, 52, 56, 60, 64 or 72 `filtTick` strobes. If `carrierSense` is sampled high inside the window, both enables stay high indefinitely.
- R6: When the window expires without carrier, the receiver goes off. The block either sleeps (all enables low) or enters calibration.
- R7: A sequence counter (modulo 256 at minimum) increments on every accepted start. `calPolicy` 0 never calibrates, 1 always calibrates, 2 calibrates when the count is a multiple of 16, and 3 when it is a multiple of 256. `calStart` stays high, with the receiver off and the synthesizer on, until `calDone` is sampled high.
- R8: A rising edge on `seqPdCtrl` puts the block to sleep from any state on the next clock. All enables go low.
- R9: If lock is not seen within `LOCK_TIMEOUT` cycles of the lock wait, `lockErr` is set and the block sleeps. `lockErr` is cleared by the next accepted start.
- R10: `rxPwrEn` never rises without `synthPwrEn`, and `calStart` is never high together with `rxPwrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdMode | input | 2 | Power mode field; 2'b11 enables sequencing |
| txMode | input | 1 | 1 selects transmit, which disables sequencing |
| startFromSel | input | 1 | 1: select pin starts sequences; 0: data pin may |
| sepDataIo | input | 1 | Separate data in/out enable, needed for data-pin start |
| selPin | input | 1 | Select pin, falling edge starts |
| dataPin | input | 1 | Data pin, falling edge starts |
| seqPdCtrl | input | 1 | Rising edge forces power-down |
| settleCode | input | 3 | Post-lock settling code |
| listenCode | input | 4 | Carrier listen window code |
| calPolicy | input | 2 | Calibration policy |
| pllLock | input | 1 | PLL lock flag |
| carrierSense | input | 1 | Carrier sense flag |
| calDone | input | 1 | Calibration finished |
| adcTick | input | 1 | One-cycle ADC clock tick |
| filtTick | input | 1 | One-cycle filter clock tick |
| synthPwrEn | output | 1 | Synthesizer power enable |
| rxPwrEn | output | 1 | Receive chain power enable |
| calStart | output | 1 | Calibration request, held until done |
| lockErr | output | 1 | Sticky lock-failure flag |

## Verification
The bench builds the block with `LOCK_TIMEOUT`=40 and the default 8-bit sequence counter. The short timeout makes a lock failure a 40-cycle event. With ticks on every cycle, every settle and listen code maps to an exact cycle count. The longest settle code (256 ticks) and the every-256th calibration policy are both within reach, because a sequence with no settle wait costs only about two dozen cycles. Slower tick rates are covered by the cycle-by-cycle model.

// File: rtl/wakeSeqPkg.sv
package wakeSeqPkg;

  typedef enum logic [2:0] {
    ST_SLEEP, ST_LOCK, ST_SETTLE, ST_LISTEN, ST_HOLD, ST_CAL
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic cntCycle;
    logic cntAdc;
    logic cntFilt;
    logic startSeq;
    logic setErr;
  } ctrlStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic startEdge;
    logic pdRise;
    logic lockTimeout;
    logic settleDone;
    logic settleSkip;
    logic listenDone;
    logic calDue;
  } dpStat_t;

  // last tick index of the settle wait (tick count minus one)
  function automatic logic [7:0] settleLast(input logic [2:0] code);
    case (code)
      3'd0:    settleLast = 8'd31;
      3'd1:    settleLast = 8'd43;
      3'd2:    settleLast = 8'd63;
      3'd3:    settleLast = 8'd87;
      3'd4:    settleLast = 8'd127;
      3'd5:    settleLast = 8'd175;
      3'd6:    settleLast = 8'd255;
      default: settleLast = 8'd0;
    endcase
  endfunction

  // last tick index of the listen window: 2 steps to 32, then 4, then 8
  function automatic logic [7:0] listenLast(input logic [3:0] code);
    logic [7:0] len;
    if (code <= 4'd6)       len = 8'd20 + {3'd0, code, 1'b0};
    else if (code <= 4'd14) len = 8'd32 + {2'd0, code - 4'd6, 2'b00};
    else                    len = 8'd72;
    listenLast = len - 8'd1;
  endfunction

endpackage

// File: rtl/wakeSeqData.sv
module wakeSeqData
  import wakeSeqPkg::*;
#(
  parameter int LOCK_TIMEOUT = 4096,
  parameter int SEQ_W        = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startFromSel,
  input  logic      sepDataIo,
  input  logic      selPin,
  input  logic      dataPin,
  input  logic      seqPdCtrl,
  input  logic [2:0] settleCode,
  input  logic [3:0] listenCode,
  input  logic [1:0] calPolicy,
  input  logic      adcTick,
  input  logic      filtTick,
  input  ctrlStrb_t strb,
  output dpStat_t   stat,
  output logic      lockErr
);
  localparam int TMR_W = $clog2((LOCK_TIMEOUT > 256) ? LOCK_TIMEOUT : 256);

  logic [TMR_W-1:0] timer;
  logic [SEQ_W-1:0] seqCnt;
  logic selPrev, dataPrev, pdPrev;
  logic timerInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev  <= 1'b1;
      dataPrev <= 1'b1;
      pdPrev   <= 1'b0;
    end else begin
      selPrev  <= selPin;
      dataPrev <= dataPin;
      pdPrev   <= seqPdCtrl;
    end
  end

  assign timerInc = strb.cntCycle | (strb.cntAdc & adcTick) | (strb.cntFilt & filtTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            timer <= '0;
    else if (strb.clrCnt) timer <= '0;
    else if (timerInc)    timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCnt  <= '0;
      lockErr <= 1'b0;
    end else begin
      if (strb.startSeq) seqCnt <= seqCnt + 1'b1;
      if (strb.setErr)        lockErr <= 1'b1;
      else if (strb.startSeq) lockErr <= 1'b0;
    end
  end

  always_comb begin
    stat.startEdge   = startFromSel ? (selPrev & ~selPin)
                                    : (sepDataIo & dataPrev & ~dataPin);
    stat.pdRise      = ~pdPrev & seqPdCtrl;
    stat.lockTimeout = (timer == TMR_W'(LOCK_TIMEOUT - 1));
    stat.settleSkip  = (settleCode == 3'd7);
    stat.settleDone  = adcTick  & (timer == TMR_W'(settleLast(settleCode)));
    stat.listenDone  = filtTick & (timer == TMR_W'(listenLast(listenCode)));
    case (calPolicy)
      2'd0:    stat.calDue = 1'b0;
      2'd1:    stat.calDue = 1'b1;
      2'd2:    stat.calDue = (seqCnt[3:0] == 4'd0);
      default: stat.calDue = (seqCnt[7:0] == 8'd0);
    endcase
  end

endmodule

// File: rtl/wakeSeqCtrl.sv
module wakeSeqCtrl
  import wakeSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pdMode,
  input  logic       txMode,
  input  logic       pllLock,
  input  logic       carrierSense,
  input  logic       calDone,
  input  dpStat_t    stat,
  output ctrlStrb_t  strb,
  output logic       synthPwrEn,
  output logic       rxPwrEn,
  output logic       calStart
);
  seqState_e st, nxt;
  logic seqEn;

  assign seqEn = (pdMode == 2'b11) & ~txMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_SLEEP;
    else       st <= nxt;
  end

  always_comb begin
    nxt  = st;
    strb = '0;
    if (!seqEn || stat.pdRise) begin
      nxt = ST_SLEEP;
    end else begin
      case (st)
        ST_SLEEP: if (stat.startEdge) begin
          nxt = ST_LOCK;
          strb.startSeq = 1'b1;
        end
        ST_LOCK: begin
          strb.cntCycle = 1'b1;
          if (pllLock) nxt = stat.settleSkip ? ST_LISTEN : ST_SETTLE;
          else if (stat.lockTimeout) begin
            nxt = ST_SLEEP;
            strb.setErr = 1'b1;
          end
        end
        ST_SETTLE: begin
          strb.cntAdc = 1'b1;
          if (stat.settleDone) nxt = ST_LISTEN;
        end
        ST_LISTEN: begin
          strb.cntFilt = 1'b1;
          if (carrierSense)         nxt = ST_HOLD;
          else if (stat.listenDone) nxt = stat.calDue ? ST_CAL : ST_SLEEP;
        end
        ST_HOLD:  nxt = ST_HOLD;
        ST_CAL:   if (calDone) nxt = ST_SLEEP;
        default:  nxt = ST_SLEEP;
      endcase
    end
    strb.clrCnt = (nxt != st);
  end

  assign synthPwrEn = (st != ST_SLEEP);
  assign rxPwrEn    = (st == ST_LISTEN) | (st == ST_HOLD);
  assign calStart   = (st == ST_CAL);

endmodule

// File: rtl/wakeSeqTop.sv
module wakeSeqTop
  import wakeSeqPkg::*;
#(
  parameter int LOCK_TIMEOUT = 4096,
  parameter int SEQ_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pdMode,
  input  logic       txMode,
  input  logic       startFromSel,
  input  logic       sepDataIo,
  input  logic       selPin,
  input  logic       dataPin,
  input  logic       seqPdCtrl,
  input  logic [2:0] settleCode,
  input  logic [3:0] listenCode,
  input  logic [1:0] calPolicy,
  input  logic       pllLock,
  input  logic       carrierSense,
  input  logic       calDone,
  input  logic       adcTick,
  input  logic       filtTick,
  output logic       synthPwrEn,
  output logic       rxPwrEn,
  output logic       calStart,
  output logic       lockErr
);
  ctrlStrb_t strb;
  dpStat_t   stat;

  wakeSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .pdMode(pdMode), .txMode(txMode),
    .pllLock(pllLock), .carrierSense(carrierSense), .calDone(calDone),
    .stat(stat), .strb(strb),
    .synthPwrEn(synthPwrEn), .rxPwrEn(rxPwrEn), .calStart(calStart)
  );

  wakeSeqData #(.LOCK_TIMEOUT(LOCK_TIMEOUT), .SEQ_W(SEQ_W)) u_data (
    .clk(clk), .rstN(rstN), .startFromSel(startFromSel), .sepDataIo(sepDataIo),
    .selPin(selPin), .dataPin(dataPin), .seqPdCtrl(seqPdCtrl),
    .settleCode(settleCode), .listenCode(listenCode), .calPolicy(calPolicy),
    .adcTick(adcTick), .filtTick(filtTick), .strb(strb), .stat(stat),
    .lockErr(lockErr)
  );

endmodule

// File: rtl/wakeSeqChk.sv
module wakeSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pdMode,
  input logic       txMode,
  input logic       seqPdCtrl,
  input logic       calDone,
  input logic       synthPwrEn,
  input logic       rxPwrEn,
  input logic       calStart,
  input logic       lockErr
);
  // R10
  rx_needs_synth_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPwrEn |-> synthPwrEn);

  // R10
  cal_rx_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> !rxPwrEn);

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdMode != 2'b11 || txMode) |=> (!synthPwrEn && !rxPwrEn && !calStart));

  // R8
  pd_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqPdCtrl) |=> !synthPwrEn);

  // R9
  err_on_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockErr) |-> (!synthPwrEn && $past(synthPwrEn) && !$past(rxPwrEn)));

  // R3
  rx_after_synth_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxPwrEn) |-> $past(synthPwrEn));

  // R7
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calStart && !calDone && pdMode == 2'b11 && !txMode && !$rose(seqPdCtrl))
      |=> calStart);
endmodule

bind wakeSeqTop wakeSeqChk u_chk (
  .clk(clk), .rstN(rstN), .pdMode(pdMode), .txMode(txMode),
  .seqPdCtrl(seqPdCtrl), .calDone(calDone), .synthPwrEn(synthPwrEn),
  .rxPwrEn(rxPwrEn), .calStart(calStart), .lockErr(lockErr)
);

// File: tb/wakeSeqTop_tb.sv
module wakeSeqTop_tb;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] pdMode = 2'b11;
  logic txMode = 0, startFromSel = 1, sepDataIo = 0;
  logic selPin = 1, dataPin = 1, seqPdCtrl = 0;
  logic [2:0] settleCode = 3'd7;
  logic [3:0] listenCode = 4'd0;
  logic [1:0] calPolicy = 2'd0;
  logic pllLock = 1, carrierSense = 0, calDone = 0;
  logic adcTick = 0, filtTick = 0;
  logic synthPwrEn, rxPwrEn, calStart, lockErr;

  int nChecks = 0, nFail = 0;
  int adcDiv = 1, filtDiv = 1, tickCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wakeSeqTop #(.LOCK_TIMEOUT(TO)) u_dut (.*);

  // tick strobes, driven away from the active edge
  always @(negedge clk) begin
    tickCnt++;
    adcTick  = (tickCnt % adcDiv) == 0;
    filtTick = (tickCnt % filtDiv) == 0;
  end

  // ---------------- behavioural reference ----------------
  int mSt = 0, mT = 0, mSeq = 0;
  bit mErr = 0, pSel = 1, pDat = 1, pPd = 0;

  function automatic int settleTicks(int c);
    int tbl[7] = '{32, 44, 64, 88, 128, 176, 256};
    return tbl[c];
  endfunction
  function automatic int listenTicks(int c);
    int tbl[16] = '{20, 22, 24, 26, 28, 30, 32, 36, 40, 44, 48, 52, 56, 60, 64, 72};
    return tbl[c];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mT = 0; mSeq = 0; mErr = 0; pSel = 1; pDat = 1; pPd = 0;
    end else begin
      bit en, go, pdr, due;
      int nx;
      en  = (pdMode == 2'b11) && !txMode;
      go  = startFromSel ? (pSel && !selPin) : (sepDataIo && pDat && !dataPin);
      pdr = !pPd && seqPdCtrl;
      due = (calPolicy == 1) || (calPolicy == 2 && mSeq % 16 == 0) ||
            (calPolicy == 3 && mSeq % 256 == 0);
      nx = mSt;
      if (!en || pdr) nx = 0;
      else case (mSt)
        0: if (go) begin nx = 1; mSeq = (mSeq + 1) % 256; mErr = 0; end
        1: if (pllLock) nx = (settleCode == 7) ? 3 : 2;
           else if (mT == TO - 1) begin nx = 0; mErr = 1; end
           else mT++;
        2: if (adcTick) begin
             if (mT == settleTicks(settleCode) - 1) nx = 3; else mT++;
           end
        3: if (carrierSense) nx = 4;
           else if (filtTick) begin
             if (mT == listenTicks(listenCode) - 1) nx = due ? 5 : 0; else mT++;
           end
        4: ;
        default: if (calDone) nx = 0;
      endcase
      if (nx != mSt) mT = 0;
      mSt = nx; pSel = selPin; pDat = dataPin; pPd = seqPdCtrl;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit es, er, ec;
      es = (mSt != 0); er = (mSt == 3 || mSt == 4); ec = (mSt == 5);
      nChecks++;
      if ({synthPwrEn, rxPwrEn, calStart, lockErr} != {es, er, ec, mErr}) begin
        nFail++;
        $display("FAIL model R3 R10 t=%0t act=%b exp=%b", $time,
                 {synthPwrEn, rxPwrEn, calStart, lockErr}, {es, er, ec, mErr});
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulseSel();
    @(negedge clk) selPin = 0;
    @(negedge clk) selPin = 1;
  endtask
  task automatic pulseData();
    @(negedge clk) dataPin = 0;
    @(negedge clk) dataPin = 1;
  endtask

  task automatic drain(output int sOnly, output int rxCyc, output int calCyc);
    sOnly = 0; rxCyc = 0; calCyc = 0;
    for (int k = 0; k < 3000 && synthPwrEn; k++) begin
      if (calStart) begin calCyc++; if (calCyc == 3) calDone = 1; end
      else if (rxPwrEn) rxCyc++;
      else sOnly++;
      @(negedge clk);
    end
    calDone = 0;
  endtask

  task automatic runSeq(output int sOnly, output int rxCyc, output int calCyc);
    pulseSel();
    drain(sOnly, rxCyc, calCyc);
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog R3 act=%0d exp=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int s, r, c, cals;
    repeat (3) @(negedge clk);
    check(!synthPwrEn && !rxPwrEn && !calStart && !lockErr, "R1 reset", synthPwrEn, 0);
    rstN = 1;
    @(negedge clk);

    // R4 / R5 / R6: code 0 settle and listen, no calibration
    settleCode = 0; listenCode = 0;
    runSeq(s, r, c);
    check(s == 33, "R4 settle code0", s, 33);
    check(r == 20, "R5 listen code0", r, 20);
    check(c == 0 && !synthPwrEn, "R6 sleep after window", c, 0);

    settleCode = 6; runSeq(s, r, c);
    check(s == 257, "R4 settle code6", s, 257);
    settleCode = 7; runSeq(s, r, c);
    check(s == 1, "R4 settle code7 skip", s, 1);

    listenCode = 15; runSeq(s, r, c);
    check(r == 72, "R5 listen code15", r, 72);
    listenCode = 7; runSeq(s, r, c);
    check(r == 36, "R5 listen code7", r, 36);

    // slower ticks: covered by model
    adcDiv = 3; filtDiv = 2; settleCode = 2; listenCode = 3;
    runSeq(s, r, c);
    check(r > 0, "R5 slow ticks rx on", r, 1);
    adcDiv = 1; filtDiv = 1; settleCode = 7; listenCode = 0;

    // R7 always calibrate
    calPolicy = 1; runSeq(s, r, c);
    check(c == 3, "R7 cal held until done", c, 3);
    check(!synthPwrEn, "R7 sleep after cal", synthPwrEn, 0);
    calPolicy = 0;

    // R9 lock timeout
    pllLock = 0; runSeq(s, r, c);
    check(s == TO, "R9 timeout length", s, TO);
    check(lockErr == 1, "R9 err set", lockErr, 1);
    pllLock = 1; pulseSel();
    check(lockErr == 0 && synthPwrEn, "R9 err cleared by start", lockErr, 0);
    drain(s, r, c);

    // R2 start source
    startFromSel = 0; sepDataIo = 1; pulseData();
    check(synthPwrEn == 1, "R2 data pin start", synthPwrEn, 1);
    drain(s, r, c);
    sepDataIo = 0; pulseData();
    check(synthPwrEn == 0, "R2 data pin without sep io", synthPwrEn, 0);
    sepDataIo = 1; pulseSel();
    check(synthPwrEn == 0, "R2 sel pin not selected", synthPwrEn, 0);
    startFromSel = 1; pulseData();
    check(synthPwrEn == 0, "R2 data pin not selected", synthPwrEn, 0);
    sepDataIo = 0;

    // R1 enable gating
    pdMode = 2'b10; pulseSel();
    check(synthPwrEn == 0, "R1 mode not 3", synthPwrEn, 0);
    pdMode = 2'b11; txMode = 1; pulseSel();
    check(synthPwrEn == 0, "R1 tx mode", synthPwrEn, 0);
    txMode = 0;
    pllLock = 0; pulseSel();
    @(negedge clk) pdMode = 2'b01;
    @(negedge clk);
    check(synthPwrEn == 0, "R1 disable mid sequence", synthPwrEn, 0);
    pdMode = 2'b11; pllLock = 1;

    // R5 hold on carrier, R8 forced power-down
    carrierSense = 1; pulseSel();
    repeat (200) @(negedge clk);
    check(rxPwrEn && synthPwrEn, "R5 hold on carrier", rxPwrEn, 1);
    seqPdCtrl = 1;
    @(negedge clk);
    check(!synthPwrEn && !rxPwrEn, "R8 forced sleep from hold", synthPwrEn, 0);
    seqPdCtrl = 0; carrierSense = 0;

    pllLock = 0; pulseSel();
    repeat (5) @(negedge clk);
    seqPdCtrl = 1;
    @(negedge clk);
    check(!synthPwrEn && !lockErr, "R8 forced sleep in lock wait", synthPwrEn, 0);
    seqPdCtrl = 0; pllLock = 1;

    // R7 every 16th
    calPolicy = 2; cals = 0;
    for (int i = 0; i < 32; i++) begin runSeq(s, r, c); if (c > 0) cals++; end
    check(cals == 2, "R7 every 16th", cals, 2);

    // R7 every 256th
    calPolicy = 3; cals = 0;
    for (int i = 0; i < 256; i++) begin runSeq(s, r, c); if (c > 0) cals++; end
    check(cals == 1, "R7 every 256th", cals, 1);

    finishRun();
  end
endmodule